// File: doc/BRIEF.md
# Frame Inversion Line Balancer (6-bit payload, 7-bit lane frame)

This block keeps the charge on one serial lane close to zero. Each valid 6-bit data word becomes a 7-bit line frame. Bits 5..0 carry the payload, either as it arrived or with every bit flipped. Bit 6 is a polarity flag: 0 means the payload is sent as-is, 1 means it is inverted. The encoder keeps a running disparity, the sum of (ones minus zeros) over every 7-bit frame sent since reset. For each new word it picks the polarity that moves this sum back toward zero. The frames then go to a bit serializer, which is not part of this block.

The matching decoder takes a 7-bit frame and XORs the payload with the flag bit to restore the original word. Its output is combinational while its valid strobe is high. It holds the last decoded word while the strobe is low.

The encoder polarity choice is a three-state machine on the sign of the running disparity:
- `RDS_ZERO`: the running disparity is exactly 0. This is the state after reset.
- `RDS_POS`: the running disparity is above 0.
- `RDS_NEG`: the running disparity is below 0.

On every accepted word the machine moves to the state that matches the sign of the updated disparity. Any state can reach any other: ZERO→POS, ZERO→NEG, POS→NEG, POS→ZERO, NEG→POS and NEG→ZERO, plus staying in POS or NEG. Without a valid word it stays where it is.

Top module: `dcb_lane_codec`

## Requirements
- R1: An encoded frame carries the polarity flag in bit 6 and the payload in bits 5..0. With flag 0 the payload equals the input word. With flag 1 it equals the bitwise inverse of the input word.
- R2: After reset the running disparity is 0. Whenever the running disparity is 0, the next word is sent with flag 0 and its payload unchanged.
- R3: The disparity of a frame is the count of ones minus the count of zeros over all 7 line bits, flag included. After each frame the running disparity changes by exactly that amount.
- R4: When the running disparity is positive, the encoder sends the polarity whose frame disparity is negative. When it is negative, the encoder sends the polarity whose frame disparity is positive.
- R5: Measured after every frame, the running disparity stays between -9 and +10 inclusive.
- R6: A word presented with `enc_din_vld` high at a clock edge appears on `enc_line` after that edge, with `enc_line_vld` high for exactly that cycle. When no word was accepted at the previous edge, `enc_line_vld` is 0.
- R7: While `enc_din_vld` is low, `enc_line` holds its last value and the running disparity does not change. The next accepted word is therefore encoded as if the idle cycles had not happened.
- R8: While `dec_line_vld` is high, `dec_dout` equals bits 5..0 of `dec_line` XOR bit 6 repeated across all six bits, in the same cycle.
- R9: While `dec_line_vld` is low, `dec_dout` holds the last word decoded with the strobe high. After reset it is 0.
- R10: Reset clears `enc_line` to 0 and `enc_line_vld` to 0.
- R11: A constant payload with no internal transitions (all zeros or all ones) still follows R4. For example, an all-zero word sent while the running disparity is negative becomes the frame 7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_din | input | 6 | Data word to encode |
| enc_din_vld | input | 1 | Marks `enc_din` as a word to encode this cycle |
| enc_line | output | 7 | Encoded frame: bit 6 is the flag, bits 5..0 the payload |
| enc_line_vld | output | 1 | High for the cycle in which a new frame is on `enc_line` |
| dec_line | input | 7 | Received frame to decode |
| dec_line_vld | input | 1 | Marks `dec_line` as a frame to decode this cycle |
| dec_dout | output | 6 | Decoded data word |

## Verification
The stimulus walks the running disparity to both of its extremes, -7 and +6. It also makes the disparity return to exactly zero several times. A sign-test error, for example treating zero as positive, would flip frames that must go out true.

Constant all-zero and all-ones words are sent in each polarity state. An encoder that ignored the sign would let the disparity run away, and the window scoreboard would catch it. Idle gaps are followed by a word whose correct encoding depends on the disparity being left unchanged. An encoder that counted a stale word during the gap would send the opposite polarity.

A reset in mid-stream checks that the disparity really returns to zero. On the decoder side, the bench changes the frame while the strobe is low. A decoder without its hold register would pass the change straight through.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Sign of the encoder running disparity
    typedef enum logic [1:0] {
        RDS_ZERO = 2'd0,
        RDS_POS  = 2'd1,
        RDS_NEG  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/dcb_popcount.sv
module dcb_popcount #(
    parameter int W = 6,
    localparam int CNT_W = $clog2(W + 2)
) (
    input  logic [W-1:0]     bits_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] partial [W+1];

    assign partial[0] = '0;

    // Linear adder chain, one stage per input bit
    for (genvar g = 0; g < W; g++) begin : g_stage
        assign partial[g+1] = partial[g] + CNT_W'(bits_i[g]);
    end

    assign count_o = partial[W];

endmodule

// File: rtl/dcb_enc_core.sv
module dcb_enc_core
    import dcb_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_vld,
    output logic [DATA_W:0]   line,
    output logic              line_vld
);

    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(DATA_W + 2);
    localparam int RD_W    = CNT_W + 3;

    rd_state_e              state_q, state_d;
    logic signed [RD_W-1:0] rd_q, rd_d;
    logic [CNT_W-1:0]       ones;
    logic signed [RD_W-1:0] ones_s;
    logic signed [RD_W-1:0] disp_true;
    logic signed [RD_W-1:0] disp_sent;
    logic                   invert_c;
    logic [DATA_W:0]        line_q;
    logic                   line_vld_q;

    dcb_popcount #(.W(DATA_W)) u_cnt (
        .bits_i  (din),
        .count_o (ones)
    );

    // Disparity of the frame if sent true: flag 0 adds one zero
    always_comb begin
        ones_s    = signed'(RD_W'(ones));
        disp_true = (ones_s <<< 1) - signed'(RD_W'(FRAME_W));
    end

    // Polarity decision from the sign state
    always_comb begin
        unique case (state_q)
            RDS_ZERO: invert_c = 1'b0;
            RDS_POS:  invert_c = (disp_true > 0);
            RDS_NEG:  invert_c = (disp_true < 0);
            default:  invert_c = 1'b0;
        endcase
        disp_sent = invert_c ? -disp_true : disp_true;
    end

    // Next running disparity and next sign state
    always_comb begin
        state_d = state_q;
        rd_d    = rd_q;
        if (din_vld) begin
            rd_d = rd_q + disp_sent;
            if (rd_d > 0) begin
                state_d = RDS_POS;
            end else if (rd_d < 0) begin
                state_d = RDS_NEG;
            end else begin
                state_d = RDS_ZERO;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RDS_ZERO;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_d;
        end
    end

    // Output register: one cycle latency, hold while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q     <= '0;
            line_vld_q <= 1'b0;
        end else begin
            line_vld_q <= din_vld;
            if (din_vld) begin
                line_q <= {invert_c, din ^ {DATA_W{invert_c}}};
            end
        end
    end

    assign line     = line_q;
    assign line_vld = line_vld_q;

endmodule

// File: rtl/dcb_dec_core.sv
module dcb_dec_core #(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W:0]   line,
    input  logic              line_vld,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] restored;
    logic [DATA_W-1:0] hold_q;

    // Per-bit polarity restore against the flag bit
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign restored[g] = line[g] ^ line[DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (line_vld) begin
            hold_q <= restored;
        end
    end

    assign dout = line_vld ? restored : hold_q;

endmodule

// File: rtl/dcb_lane_codec.sv
module dcb_lane_codec #(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_din,
    input  logic              enc_din_vld,
    output logic [DATA_W:0]   enc_line,
    output logic              enc_line_vld,
    input  logic [DATA_W:0]   dec_line,
    input  logic              dec_line_vld,
    output logic [DATA_W-1:0] dec_dout
);

    dcb_enc_core #(.DATA_W(DATA_W)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (enc_din),
        .din_vld  (enc_din_vld),
        .line     (enc_line),
        .line_vld (enc_line_vld)
    );

    dcb_dec_core #(.DATA_W(DATA_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (dec_line),
        .line_vld (dec_line_vld),
        .dout     (dec_dout)
    );

endmodule

// File: rtl/dcb_lane_codec_chk.sv
module dcb_lane_codec_chk #(
    parameter int DATA_W = 6,
    parameter int RD_HI  = 10,
    parameter int RD_LO  = -9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_din_vld,
    input  logic [DATA_W:0]   enc_line,
    input  logic              enc_line_vld,
    input  logic              dec_line_vld,
    input  logic [DATA_W-1:0] dec_dout
);

    localparam int FRAME_W = DATA_W + 1;

    int frame_disp;
    int rd_mdl;

    // Disparity observed on the encoder output
    always_comb frame_disp = 2 * $countones(enc_line) - FRAME_W;

    // Running disparity rebuilt from the line frames only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mdl <= 0;
        end else if (enc_line_vld) begin
            rd_mdl <= rd_mdl + frame_disp;
        end
    end

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mdl <= RD_HI) && (rd_mdl >= RD_LO)); // R5

    AST_POS_PULLS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_line_vld && rd_mdl > 0) |-> (frame_disp < 0)); // R4

    AST_NEG_PULLS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_line_vld && rd_mdl < 0) |-> (frame_disp > 0)); // R4

    AST_ZERO_SENDS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_line_vld && rd_mdl == 0) |-> !enc_line[DATA_W]); // R2

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        enc_din_vld |=> enc_line_vld); // R6

    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_din_vld |=> !enc_line_vld); // R6

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_din_vld |=> $stable(enc_line)); // R7

    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_line_vld && !$past(dec_line_vld)) |-> $stable(dec_dout)); // R9

endmodule

bind dcb_lane_codec dcb_lane_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_din_vld  (enc_din_vld),
    .enc_line     (enc_line),
    .enc_line_vld (enc_line_vld),
    .dec_line_vld (dec_line_vld),
    .dec_dout     (dec_dout)
);

// File: tb/sim_dcb_lane_codec.sv
module sim_dcb_lane_codec;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] enc_din;
    logic       enc_din_vld;
    logic [6:0] enc_line;
    logic       enc_line_vld;
    logic [6:0] dec_line;
    logic       dec_line_vld;
    logic [5:0] dec_dout;

    int errs   = 0;
    int checks = 0;
    int rd_sb  = 0;

    always #4 clk = ~clk;

    dcb_lane_codec u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_din      (enc_din),
        .enc_din_vld  (enc_din_vld),
        .enc_line     (enc_line),
        .enc_line_vld (enc_line_vld),
        .dec_line     (dec_line),
        .dec_line_vld (dec_line_vld),
        .dec_dout     (dec_dout)
    );

    // {input word, expected frame}, starting from running disparity 0
    localparam logic [12:0] VEC [20] = '{
        {6'b000000, 7'h00}, {6'b000000, 7'h7F}, {6'b111111, 7'h3F}, {6'b111111, 7'h40},
        {6'b101010, 7'h2A}, {6'b000001, 7'h7E}, {6'b110000, 7'h30}, {6'b011111, 7'h60},
        {6'b111000, 7'h47}, {6'b111100, 7'h3C}, {6'b000000, 7'h00}, {6'b001000, 7'h77},
        {6'b111110, 7'h3E}, {6'b000000, 7'h00}, {6'b000000, 7'h7F}, {6'b010101, 7'h15},
        {6'b101010, 7'h2A}, {6'b000000, 7'h7F}, {6'b111111, 7'h40}, {6'b111111, 7'h40}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [5:0] d);
        @(negedge clk);
        enc_din     = d;
        enc_din_vld = 1'b1;
        @(negedge clk);
        enc_din_vld = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        enc_din      = '0;
        enc_din_vld  = 1'b0;
        dec_line     = '0;
        dec_line_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 line after reset", 32'(enc_line), 32'h0);
        chk("R10 line_vld after reset", 32'(enc_line_vld), 32'h0);
        chk("R9 dec_dout after reset", 32'(dec_dout), 32'h0);
        rst_n = 1'b1;

        // Table walk, back to back, R1 R3 R4 R5 R8
        for (int i = 0; i < 20; i++) begin
            enc_din     = VEC[i][12:7];
            enc_din_vld = 1'b1;
            @(negedge clk);
            chk("R1 R3 R4 frame", 32'(enc_line), 32'(VEC[i][6:0]));
            chk("R6 line_vld", 32'(enc_line_vld), 32'h1);
            rd_sb = rd_sb + 2 * $countones(enc_line) - 7;
            chk("R5 window", 32'((rd_sb <= 10) && (rd_sb >= -9)), 32'h1);
            dec_line     = enc_line;
            dec_line_vld = 1'b1;
            #1;
            chk("R8 decode", 32'(dec_dout), 32'(VEC[i][12:7]));
        end
        enc_din_vld  = 1'b0;
        dec_line_vld = 1'b0;
        enc_din      = 6'b111111;

        // Idle gap: output and running disparity (-4) hold, R6 R7
        repeat (3) begin
            @(negedge clk);
            chk("R7 line hold", 32'(enc_line), 32'h40);
            chk("R6 line_vld idle", 32'(enc_line_vld), 32'h0);
        end
        send_frame(6'b000000);
        chk("R7 disparity unchanged over idle", 32'(enc_line), 32'h7F);

        // Decoder directed, R8 R9
        @(negedge clk);
        dec_line     = 7'h55;
        dec_line_vld = 1'b1;
        #1;
        chk("R8 flag set", 32'(dec_dout), 32'h2A);
        @(negedge clk);
        dec_line     = 7'h00;
        dec_line_vld = 1'b0;
        #1;
        chk("R9 dec hold", 32'(dec_dout), 32'h2A);
        @(negedge clk);
        chk("R9 dec hold later", 32'(dec_dout), 32'h2A);
        dec_line     = 7'h2B;
        dec_line_vld = 1'b1;
        #1;
        chk("R8 flag clear", 32'(dec_dout), 32'h2B);
        @(negedge clk);
        dec_line_vld = 1'b0;

        // Mid-stream reset, R10 R2 R11
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 line after mid reset", 32'(enc_line), 32'h0);
        chk("R9 dec_dout after mid reset", 32'(dec_dout), 32'h0);
        rst_n = 1'b1;
        send_frame(6'b000000);
        chk("R2 R11 first frame true", 32'(enc_line), 32'h00);
        send_frame(6'b000000);
        chk("R11 zeros inverted when negative", 32'(enc_line), 32'h7F);
        send_frame(6'b111111);
        chk("R2 zero disparity sends true", 32'(enc_line), 32'h3F);
        send_frame(6'b111111);
        chk("R11 ones inverted when positive", 32'(enc_line), 32'h40);

        finish_run();
    end

endmodule